// File: doc/BRIEF.md
# Bus I/O recovery delay timer

This block spaces consecutive I/O cycles on an expansion bus. When the bus sequencer finishes an I/O cycle it pulses a completion strobe, tagged with the cycle's data width and with a flag that marks sub-cycles split off by byte assembly or disassembly. The block then holds its "start allowed" output low for a recovery gap. The gap depends on the width of the cycle and on a configuration byte. The sequencer must wait for that output before it launches the next I/O cycle.

The counter runs on a clock at twice the bus-clock rate, so every gap is counted in half bus clocks. The fixed fallback gap of three and a half bus clocks is therefore exact. Each width has its own enable bit and delay code. A delay code of all zeros selects the largest delay of its field. When a width's enable bit is clear, the fixed gap is used. Split sub-cycles get no gap. A strobe that arrives while a gap is still running restarts the count with the new cycle's delay.

Top module: `iorec_timer`

## Requirements
- R1: On the clock edge where the synchronous active-low reset is sampled low, the gap counter is cleared. With no strobe present, `start_ok` is high on the cycle after reset.
- R2: When `cfg[6]`=1 (narrow recovery enabled), a narrow, non-split strobe with code k = `cfg[5:3]` in 1..7 makes `start_ok` low for 2k fast-clock cycles after the strobe cycle.
- R3: When `cfg[6]`=1, narrow code `cfg[5:3]`=000 gives 16 fast-clock cycles (8 bus clocks).
- R4: When `cfg[2]`=1 (wide recovery enabled), a wide, non-split strobe with code k = `cfg[1:0]` in 1..3 makes `start_ok` low for 2k fast-clock cycles after the strobe cycle.
- R5: When `cfg[2]`=1, wide code `cfg[1:0]`=00 gives 8 fast-clock cycles (4 bus clocks).
- R6: When the enable bit for the strobe's width is 0, the gap is 7 fast-clock cycles (3.5 bus clocks), whatever that width's code field holds.
- R7: A strobe with `done_split`=1 adds no gap: `start_ok` is high on the cycle after the strobe.
- R8: `start_ok` is low in any cycle where `done` is high.
- R9: A strobe that arrives while a gap is counting reloads the counter. The new gap is the delay for the new strobe's width, counted from the new strobe.
- R10: `done_wide`=1 selects the wide fields (`cfg[2]`, `cfg[1:0]`). `done_wide`=0 selects the narrow fields (`cfg[6]`, `cfg[5:3]`). The fields of the other width have no effect on the gap.
- R11: The default configuration value 8'h4D (both enables set, both codes 1) gives a 2-cycle gap for both widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the bus-clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg | input | 8 | Recovery configuration byte |
| done | input | 1 | One-cycle strobe: an I/O cycle has completed |
| done_wide | input | 1 | Width of the completed cycle: 1 = 16-bit, 0 = 8-bit |
| done_split | input | 1 | Completed cycle was a byte assembly/disassembly sub-cycle |
| start_ok | output | 1 | High when the next I/O cycle may start |

## Verification
Two functions can fall in the same cycle: a fresh completion strobe and a gap counter that is still counting down. The bench provokes this in two steps. It first strobes a narrow cycle with a long code. Three cycles into that gap, it strobes a wide cycle with a short code. A correct design reloads the counter rather than decrementing or keeping the old value. The bench judges this by counting the low cycles of `start_ok` after the second strobe and comparing the count with the wide delay alone. It also checks that `start_ok` is low during the strobe cycle itself, even when the counter is already zero.

// File: rtl/iorec_pkg.sv
// Package iorec_pkg: shared widths and constants of the I/O recovery timer.
// Assumes a configuration byte with the narrow enable and code in the upper
// half and the wide enable and code in the lower half.
package iorec_pkg;
    localparam int NARROW_CODE_W = 3;
    localparam int WIDE_CODE_W   = 2;
    // fallback gap in half bus clocks (3.5 bus clocks)
    localparam int FIXED_HALF    = 7;
    localparam int MAX_HALF      = 2 * (1 << NARROW_CODE_W);
    localparam int CNT_W         = $clog2(MAX_HALF + 1);
    // both enables set, both codes equal to one
    localparam logic [7:0] CFG_DEFAULT = 8'h4D;

    typedef logic [CNT_W-1:0] half_t;
endpackage

// File: rtl/rec_field_decode.sv
// Module rec_field_decode: turns one width's enable bit and delay code into a
// gap length in half bus clocks. A zero code means the largest delay of the
// field. A clear enable selects the fixed fallback gap.
// Assumes CNT_W can hold 2 * 2**FIELD_W.
module rec_field_decode #(
    parameter int FIELD_W    = 3,
    parameter int CNT_W      = 5,
    parameter int FIXED_HALF = 7
) (
    input  logic               en,
    input  logic [FIELD_W-1:0] code,
    output logic [CNT_W-1:0]   half
);
    localparam int TOP_HALF = 2 * (1 << FIELD_W);

    // Purpose: map the code to a gap length, with wrap-around for code zero.
    always_comb begin
        if (!en)
            half = CNT_W'(FIXED_HALF);
        else if (code == '0)
            half = CNT_W'(TOP_HALF);
        else
            half = CNT_W'({code, 1'b0});
    end
endmodule

// File: rtl/rec_gap_counter.sv
// Module rec_gap_counter: down counter for the recovery gap. A load always
// wins over the decrement, so a new strobe restarts the gap.
// Assumes load_val fits in CNT_W bits.
module rec_gap_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             busy
);
    // Purpose: reset, reload on a strobe, else count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Purpose: flag a gap that is still running.
    always_comb busy = (cnt != '0);

    // R9: with no reload, a running count drops by exactly one per cycle
    a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/iorec_timer.sv
// Module iorec_timer: enforces the recovery gap between I/O cycles on an
// expansion bus. Decodes a gap for each width, selects one from the strobe's
// width and split flag, and holds start_ok low until the counter drains.
// Assumes clk runs at twice the bus-clock rate and done is a one-cycle pulse.
module iorec_timer
    import iorec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg,
    input  logic       done,
    input  logic       done_wide,
    input  logic       done_split,
    output logic       start_ok
);
    localparam int NUM_W = 2;  // index 0 = narrow, 1 = wide

    half_t gap_by_w [NUM_W];
    half_t gap_sel;
    half_t cnt;
    logic  busy;

    // one decoder per width; the register bit positions differ per width
    for (genvar w = 0; w < NUM_W; w++) begin : g_width
        if (w == 0) begin : g_narrow
            rec_field_decode #(
                .FIELD_W(NARROW_CODE_W), .CNT_W(CNT_W), .FIXED_HALF(FIXED_HALF)
            ) u_dec (
                .en(cfg[6]), .code(cfg[5:3]), .half(gap_by_w[w])
            );
        end else begin : g_wide
            rec_field_decode #(
                .FIELD_W(WIDE_CODE_W), .CNT_W(CNT_W), .FIXED_HALF(FIXED_HALF)
            ) u_dec (
                .en(cfg[2]), .code(cfg[1:0]), .half(gap_by_w[w])
            );
        end
    end

    // Purpose: pick the gap for this strobe; split sub-cycles get none.
    always_comb gap_sel = done_split ? '0 : gap_by_w[done_wide];

    rec_gap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(done), .load_val(gap_sel),
        .cnt(cnt), .busy(busy)
    );

    // Purpose: allow a new cycle only when idle and not in a strobe cycle.
    always_comb start_ok = !busy && !done;

    // R7: a split sub-cycle leaves the bus free on the next cycle
    a_r7_split_free: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_split) |=> (start_ok || done));

    // R6: a disabled narrow width loads the fixed gap
    a_r6_fixed_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_split && !done_wide && !cfg[6]) |=> (cnt == CNT_W'(FIXED_HALF)));

    // R2: an enabled narrow width loads an even gap of 2..16
    a_r2_narrow_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_split && !done_wide && cfg[6])
        |=> (cnt >= CNT_W'(2) && cnt <= CNT_W'(MAX_HALF) && !cnt[0]));

    // R4: an enabled wide width loads an even gap of 2..8
    a_r4_wide_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_split && done_wide && cfg[2])
        |=> (cnt >= CNT_W'(2) && cnt <= CNT_W'(8) && !cnt[0]));
endmodule

// File: tb/sim_iorec_timer.sv
module sim_iorec_timer;
    import iorec_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg = 8'h00;
    logic       done = 1'b0;
    logic       done_wide = 1'b0;
    logic       done_split = 1'b0;
    logic       start_ok;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    iorec_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .done(done),
        .done_wide(done_wide), .done_split(done_split), .start_ok(start_ok)
    );

    // {cfg, wide, split, expected low cycles}
    localparam int NV = 13;
    localparam logic [14:0] VEC [NV] = '{
        {8'h48, 1'b0, 1'b0, 5'd2},   // R2 code 1
        {8'h68, 1'b0, 1'b0, 5'd10},  // R2 code 5
        {8'h78, 1'b0, 1'b0, 5'd14},  // R2 code 7
        {8'h40, 1'b0, 1'b0, 5'd16},  // R3 code 0
        {8'h05, 1'b1, 1'b0, 5'd2},   // R4 code 1
        {8'h07, 1'b1, 1'b0, 5'd6},   // R4 code 3
        {8'h04, 1'b1, 1'b0, 5'd8},   // R5 code 0
        {8'h38, 1'b0, 1'b0, 5'd7},   // R6 narrow disabled, field 7
        {8'h03, 1'b1, 1'b0, 5'd7},   // R6 wide disabled, field 3
        {8'h78, 1'b0, 1'b1, 5'd0},   // R7 split narrow
        {8'h04, 1'b1, 1'b1, 5'd0},   // R7 split wide
        {8'h7C, 1'b0, 1'b0, 5'd14},  // R10 narrow fields chosen
        {8'h7C, 1'b1, 1'b0, 5'd8}    // R10 wide fields chosen
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one strobe; checks R8 in the strobe cycle
    task automatic strobe(input logic w, input logic s);
        @(negedge clk);
        done = 1'b1; done_wide = w; done_split = s;
        #1 check("R8", int'(start_ok), 0);
        @(negedge clk);
        done = 1'b0; done_wide = 1'b0; done_split = 1'b0;
        #1;
    endtask

    // counts low cycles of start_ok from the current sample point
    task automatic measure(output int n);
        n = 0;
        while (!start_ok && n < 40) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 after reset", int'(start_ok), 1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg = VEC[i][14:7];
            strobe(VEC[i][6], VEC[i][5]);
            measure(got);
            check($sformatf("R2-R7,R10 vector %0d", i), got, int'(VEC[i][4:0]));
        end

        // R9: a wide strobe during a long narrow gap restarts with the wide delay
        cfg = 8'h7D;  // narrow code 7 -> 14, wide code 1 -> 2
        strobe(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        #1 check("R9 still counting", int'(start_ok), 0);
        strobe(1'b1, 1'b0);
        measure(got);
        check("R9 restart gap", got, 2);

        // R11: default configuration, both widths
        cfg = CFG_DEFAULT;
        strobe(1'b0, 1'b0);
        measure(got);
        check("R11 narrow", got, 2);
        strobe(1'b1, 1'b0);
        measure(got);
        check("R11 wide", got, 2);

        // R1: reset in the middle of a gap clears it
        cfg = 8'h40;
        strobe(1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 mid-gap reset", int'(start_ok), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule